// File: doc/BRIEF.md
# Decimal Accumulator Machine Sequencer

This block is a multi-cycle controller and datapath for a small computer that works on three-digit decimal words, each digit held as a 4-bit BCD nibble. It keeps a two-digit program counter, an address latch and a data latch in front of a 100-word store, an instruction register, a three-digit accumulator, and separate negative and zero flags. Each instruction is first fetched in a fixed series of register transfers. An execute phase chosen by the opcode follows.

The machine comes out of reset halted. While it is halted, the host fills the word store through a preload port. A one-cycle `run` pulse then starts execution at address 00. Programs read values from `in_data` and show results as strobed values on `out_data`. When the machine meets a stop code it halts, and it stays halted until the next `run` pulse.

Top module: `dacc_seq`

## Requirements
- R1: After reset, `halted` is 1, `out_strobe` is 0 and `out_data` is 000.
- R2: Preload writes (`pre_addr` two BCD digits, `pre_data` three BCD digits) take effect only while halted. They are ignored while a program runs. A `run` pulse sets the program counter to 00 and clears `halted` on the next edge.
- R3: The fetch takes three clock cycles: address latch from PC, then data latch from the store together with the PC increment, then instruction register from the data latch. One decode/execute cycle follows. A non-memory instruction therefore takes 4 cycles and a memory-operand instruction takes 7. The first OUT at address 00 strobes 4 cycles after the `run` edge.
- R4: The leading BCD digit selects the operation: 1 add, 2 subtract, 3 store, 5 load, 6 branch always, 7 branch if zero, 8 branch if not negative. The full codes 901 and 902 are input and output. The low two digits give the operand address.
- R5: Add forms (ACC + word) modulo 1000 in BCD and clears the negative flag.
- R6: Subtract forms (ACC − word) modulo 1000 in BCD. It sets the negative flag exactly when the true difference is below zero.
- R7: Load copies a word into ACC and clears the negative flag. Store writes ACC to the addressed word.
- R8: Branch always loads PC with the low two digits of the instruction.
- R9: The zero flag is set exactly when ACC is 000. Branch-if-zero is taken only when the zero flag is set. Branch-if-not-negative is taken only when the negative flag is clear.
- R10: Input (901) loads ACC from `in_data` and clears the negative flag. Output (902) places ACC on `out_data`, which holds the value, and pulses `out_strobe` high for one cycle.
- R11: Code 000 and any code not listed in R4 halt the machine. No fetch or output follows until `run` is pulsed again.
- R12: The program counter wraps from 99 to 00.
- R13: Every digit of ACC and PC stays a valid BCD digit (0–9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start pulse: PC to 00, leave halt |
| halted | output | 1 | High while the machine is stopped |
| in_data | input | 12 | Three BCD digits read by the input instruction |
| out_data | output | 12 | Three BCD digits from the last output instruction |
| out_strobe | output | 1 | One-cycle pulse when `out_data` is refreshed |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload address, two BCD digits |
| pre_data | input | 12 | Preload word, three BCD digits |

## Verification
State inside the machine reaches the ports only through output values, the spacing of strobes, and when the machine halts. A wrong accumulator digit or carry shows up at the next output instruction. A stray flag or a wrong branch target changes which outputs appear and in what order. A fetch step that is too slow or too fast moves every strobe by whole cycles. Programs therefore end by dumping the accumulator and the stored words through output instructions, so that a corrupted value shows up within a few instructions of where it arose.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  localparam int DIG_W       = 4;
  localparam int WORD_DIGITS = 3;
  localparam int ADDR_DIGITS = 2;
  localparam int WORD_W      = DIG_W * WORD_DIGITS;
  localparam int ADDR_W      = DIG_W * ADDR_DIGITS;
  localparam int NUM_WORDS   = 10 ** ADDR_DIGITS;
  localparam int IDX_W       = $clog2(NUM_WORDS);

  typedef enum logic [3:0] {
    ST_HALT, ST_FMAR, ST_FMDR, ST_FIR, ST_DEC,
    ST_XMAR, ST_XMDR, ST_XALU, ST_XWR
  } state_e;

  typedef enum logic [3:0] {
    OP_HLT, OP_ADD, OP_SUB, OP_STO, OP_LDA,
    OP_BRA, OP_BRZ, OP_BRP, OP_IN, OP_OUT
  } op_e;

  function automatic op_e decode_op(input logic [WORD_W-1:0] word);
    op_e op;
    case (word[WORD_W-1 -: DIG_W])
      4'd1: op = OP_ADD;
      4'd2: op = OP_SUB;
      4'd3: op = OP_STO;
      4'd5: op = OP_LDA;
      4'd6: op = OP_BRA;
      4'd7: op = OP_BRZ;
      4'd8: op = OP_BRP;
      4'd9: begin
        if (word[ADDR_W-1:0] == 8'h01)      op = OP_IN;
        else if (word[ADDR_W-1:0] == 8'h02) op = OP_OUT;
        else                                op = OP_HLT;
      end
      default: op = OP_HLT;
    endcase
    return op;
  endfunction

  // Two-digit BCD address to linear store index
  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return IDX_W'(a[7:4]) * IDX_W'(10) + IDX_W'(a[3:0]);
  endfunction

  // Two-digit BCD increment, 99 wraps to 00
  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    logic [3:0] lo, hi;
    lo = (a[3:0] == 4'd9) ? 4'd0 : a[3:0] + 4'd1;
    hi = a[7:4];
    if (a[3:0] == 4'd9) hi = (a[7:4] == 4'd9) ? 4'd0 : a[7:4] + 4'd1;
    return {hi, lo};
  endfunction

  function automatic logic all_digits_ok(input logic [WORD_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < WORD_DIGITS; d++)
      if (w[d*DIG_W +: DIG_W] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/dacc_alu.sv
module dacc_alu
  import dacc_pkg::*;
#(
  parameter int NDIG = WORD_DIGITS
) (
  input  logic [4*NDIG-1:0] a_i,
  input  logic [4*NDIG-1:0] b_i,
  input  logic              sub_i,
  output logic [4*NDIG-1:0] res_o,
  output logic              borrow_o
);
  localparam int W = 4 * NDIG;

  logic [NDIG:0] carry;
  assign carry[0] = sub_i;

  // Ripple of decimal digit adders; subtraction uses nines complement plus one
  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [3:0] bd;
    logic [4:0] raw;
    assign bd  = sub_i ? (4'd9 - b_i[4*d +: 4]) : b_i[4*d +: 4];
    assign raw = {1'b0, a_i[4*d +: 4]} + {1'b0, bd} + {4'd0, carry[d]};
    assign carry[d+1]    = (raw > 5'd9);
    assign res_o[4*d +: 4] = carry[d+1] ? 4'(raw + 5'd6) : raw[3:0];
  end

  // Without a final carry, a subtraction went below zero
  assign borrow_o = sub_i & ~carry[NDIG];

  logic unused_w;
  assign unused_w = (W == 0);

endmodule

// File: rtl/dacc_store.sv
module dacc_store
  import dacc_pkg::*;
#(
  parameter int DEPTH = NUM_WORDS,
  parameter int DW    = WORD_W,
  parameter int AW    = ADDR_W
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) words[addr_index(waddr_i)] <= wdata_i;
  end

  assign rdata_o = words[addr_index(raddr_i)];

endmodule

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] ir,
  input  logic              nf,
  input  logic              zf,
  output logic              halted,
  output logic              ev_fetch_mar,
  output logic              ev_fetch_mdr,
  output logic              ev_ir_load,
  output logic              ev_br,
  output logic              ev_x_mar,
  output logic              ev_x_mdr_mem,
  output logic              ev_x_mdr_acc,
  output logic              ev_mem_we,
  output logic              ev_acc_alu,
  output logic              ev_acc_load,
  output logic              ev_acc_in,
  output logic              ev_out,
  output logic              alu_sub
);
  state_e st, st_nxt;
  op_e    op;

  assign op = decode_op(ir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= ST_HALT;
    else if (run) st <= ST_FMAR;
    else          st <= st_nxt;
  end

  always_comb begin
    st_nxt = st;
    case (st)
      ST_HALT: st_nxt = ST_HALT;
      ST_FMAR: st_nxt = ST_FMDR;
      ST_FMDR: st_nxt = ST_FIR;
      ST_FIR:  st_nxt = ST_DEC;
      ST_DEC: begin
        case (op)
          OP_ADD, OP_SUB, OP_STO, OP_LDA: st_nxt = ST_XMAR;
          OP_HLT:                         st_nxt = ST_HALT;
          default:                        st_nxt = ST_FMAR;
        endcase
      end
      ST_XMAR: st_nxt = ST_XMDR;
      ST_XMDR: st_nxt = (op == OP_STO) ? ST_XWR : ST_XALU;
      ST_XALU: st_nxt = ST_FMAR;
      ST_XWR:  st_nxt = ST_FMAR;
      default: st_nxt = ST_HALT;
    endcase
  end

  logic go, in_dec, take;
  assign go     = ~run;
  assign in_dec = go & (st == ST_DEC);
  assign take   = (op == OP_BRA) | ((op == OP_BRZ) & zf) | ((op == OP_BRP) & ~nf);

  assign halted       = (st == ST_HALT);
  assign ev_fetch_mar = go & (st == ST_FMAR);
  assign ev_fetch_mdr = go & (st == ST_FMDR);
  assign ev_ir_load   = go & (st == ST_FIR);
  assign ev_br        = in_dec & take;
  assign ev_acc_in    = in_dec & (op == OP_IN);
  assign ev_out       = in_dec & (op == OP_OUT);
  assign ev_x_mar     = go & (st == ST_XMAR);
  assign ev_x_mdr_mem = go & (st == ST_XMDR) & (op != OP_STO);
  assign ev_x_mdr_acc = go & (st == ST_XMDR) & (op == OP_STO);
  assign ev_mem_we    = go & (st == ST_XWR);
  assign ev_acc_alu   = go & (st == ST_XALU) & ((op == OP_ADD) | (op == OP_SUB));
  assign ev_acc_load  = go & (st == ST_XALU) & (op == OP_LDA);
  assign alu_sub      = (op == OP_SUB);

endmodule

// File: rtl/dacc_seq.sv
module dacc_seq
  import dacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              halted,
  input  logic [WORD_W-1:0] in_data,
  output logic [WORD_W-1:0] out_data,
  output logic              out_strobe,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data
);
  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] mdr, ir, acc;
  logic              nf, zf;

  logic ev_fetch_mar, ev_fetch_mdr, ev_ir_load, ev_br;
  logic ev_x_mar, ev_x_mdr_mem, ev_x_mdr_acc, ev_mem_we;
  logic ev_acc_alu, ev_acc_load, ev_acc_in, ev_out, alu_sub;

  dacc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .ir           (ir),
    .nf           (nf),
    .zf           (zf),
    .halted       (halted),
    .ev_fetch_mar (ev_fetch_mar),
    .ev_fetch_mdr (ev_fetch_mdr),
    .ev_ir_load   (ev_ir_load),
    .ev_br        (ev_br),
    .ev_x_mar     (ev_x_mar),
    .ev_x_mdr_mem (ev_x_mdr_mem),
    .ev_x_mdr_acc (ev_x_mdr_acc),
    .ev_mem_we    (ev_mem_we),
    .ev_acc_alu   (ev_acc_alu),
    .ev_acc_load  (ev_acc_load),
    .ev_acc_in    (ev_acc_in),
    .ev_out       (ev_out),
    .alu_sub      (alu_sub)
  );

  // Store port: the machine owns it while running, the host while halted
  logic              st_we, pre_ok;
  logic [ADDR_W-1:0] st_waddr;
  logic [WORD_W-1:0] st_wdata, st_rdata;

  assign pre_ok   = halted & pre_we;
  assign st_we    = ev_mem_we | pre_ok;
  assign st_waddr = ev_mem_we ? mar : pre_addr;
  assign st_wdata = ev_mem_we ? mdr : pre_data;

  dacc_store u_store (
    .clk     (clk),
    .we_i    (st_we),
    .waddr_i (st_waddr),
    .wdata_i (st_wdata),
    .raddr_i (mar),
    .rdata_o (st_rdata)
  );

  logic [WORD_W-1:0] alu_res;
  logic              alu_borrow;

  dacc_alu u_alu (
    .a_i      (acc),
    .b_i      (mdr),
    .sub_i    (alu_sub),
    .res_o    (alu_res),
    .borrow_o (alu_borrow)
  );

  // Accumulator source selection
  logic              acc_we;
  logic [WORD_W-1:0] acc_nxt;
  logic              nf_nxt;

  always_comb begin
    acc_we  = 1'b1;
    acc_nxt = acc;
    nf_nxt  = nf;
    if (ev_acc_alu) begin
      acc_nxt = alu_res;
      nf_nxt  = alu_borrow;
    end else if (ev_acc_load) begin
      acc_nxt = mdr;
      nf_nxt  = 1'b0;
    end else if (ev_acc_in) begin
      acc_nxt = in_data;
      nf_nxt  = 1'b0;
    end else begin
      acc_we  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      mar        <= '0;
      mdr        <= '0;
      ir         <= '0;
      acc        <= '0;
      nf         <= 1'b0;
      zf         <= 1'b1;
      out_data   <= '0;
      out_strobe <= 1'b0;
    end else begin
      out_strobe <= ev_out;
      if (run)               pc <= '0;
      else if (ev_fetch_mdr) pc <= addr_inc(pc);
      else if (ev_br)        pc <= ir[ADDR_W-1:0];

      if (ev_fetch_mar)  mar <= pc;
      else if (ev_x_mar) mar <= ir[ADDR_W-1:0];

      if (ev_fetch_mdr | ev_x_mdr_mem) mdr <= st_rdata;
      else if (ev_x_mdr_acc)           mdr <= acc;

      if (ev_ir_load) ir <= mdr;

      if (acc_we) begin
        acc <= acc_nxt;
        nf  <= nf_nxt;
        zf  <= (acc_nxt == '0);
      end

      if (ev_out) out_data <= acc;
    end
  end

endmodule

// File: rtl/dacc_chk.sv
module dacc_chk
  import dacc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              halted,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] mar,
  input logic [WORD_W-1:0] ir,
  input logic [WORD_W-1:0] acc,
  input logic              zf,
  input logic              ev_fetch_mar,
  input logic              ev_fetch_mdr,
  input logic              ev_ir_load,
  input logic              ev_br,
  input logic              ev_mem_we,
  input logic              out_strobe
);

  assert_run_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (pc == '0) && !halted);

  assert_fetch_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_mdr |-> $past(ev_fetch_mar));

  assert_ir_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ir_load |-> $past(ev_fetch_mdr));

  assert_store_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_we |-> !halted);

  assert_branch_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_br |=> (pc == $past(ir[ADDR_W-1:0])) && $stable(mar));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zf == (acc == '0));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);

  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !run) |=> halted && $stable(pc));

  assert_bcd_digits_R13: assert property (@(posedge clk) disable iff (!rst_n)
    all_digits_ok(acc) && (pc[7:4] <= 4'd9) && (pc[3:0] <= 4'd9));

endmodule

bind dacc_seq dacc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .halted       (halted),
  .pc           (pc),
  .mar          (mar),
  .ir           (ir),
  .acc          (acc),
  .zf           (zf),
  .ev_fetch_mar (ev_fetch_mar),
  .ev_fetch_mdr (ev_fetch_mdr),
  .ev_ir_load   (ev_ir_load),
  .ev_br        (ev_br),
  .ev_mem_we    (ev_mem_we),
  .out_strobe   (out_strobe)
);

// File: tb/test_dacc_seq.sv
`timescale 1ns/1ps
module test_dacc_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = '0;
  logic [11:0] pre_data = '0;
  logic [11:0] in_data = '0;
  logic        halted, out_strobe;
  logic [11:0] out_data;

  dacc_seq i_dacc_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .halted     (halted),
    .in_data    (in_data),
    .out_data   (out_data),
    .out_strobe (out_strobe),
    .pre_we     (pre_we),
    .pre_addr   (pre_addr),
    .pre_data   (pre_data)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int prog [100];
  int exp_out [256];
  int n_exp;
  int got_out [256];
  int got_k [256];
  int n_got;
  int acc_m = 0;
  bit neg_m = 1'b0;

  function automatic logic [11:0] to_bcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(input logic [11:0] b);
    return int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bit bcd_ok(input logic [11:0] b);
    return (b[11:8] <= 4'd9) && (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Instruction-level model of the machine
  task automatic model_run(input int in_val);
    int m [100];
    int pc, ins, a, d;
    bit stop;
    for (int i = 0; i < 100; i++) m[i] = prog[i];
    pc = 0; n_exp = 0; stop = 1'b0;
    for (int step = 0; step < 3000 && !stop; step++) begin
      ins = m[pc];
      pc  = (pc + 1) % 100;
      a   = ins % 100;
      case (ins / 100)
        1: begin acc_m = (acc_m + m[a]) % 1000; neg_m = 1'b0; end
        2: begin d = acc_m - m[a]; neg_m = (d < 0); acc_m = (d + 1000) % 1000; end
        3: m[a] = acc_m;
        5: begin acc_m = m[a]; neg_m = 1'b0; end
        6: pc = a;
        7: if (acc_m == 0) pc = a;
        8: if (!neg_m) pc = a;
        9: begin
          if (ins == 901) begin acc_m = in_val; neg_m = 1'b0; end
          else if (ins == 902) begin exp_out[n_exp] = acc_m; n_exp++; end
          else stop = 1'b1;
        end
        default: stop = 1'b1;
      endcase
    end
  endtask

  task automatic load_prog();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      pre_we   = 1'b1;
      pre_addr = to_bcd(i)[7:0];
      pre_data = to_bcd(prog[i]);
    end
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic pulse_run();
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
  endtask

  // k counts negedges after the one that drops run; an OUT at 00 strobes at k=3
  task automatic run_dut(input bit inject);
    n_got = 0;
    pulse_run();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (out_strobe && n_got < 256) begin
        got_out[n_got] = from_bcd(out_data);
        got_k[n_got]   = k;
        check(bcd_ok(out_data), "R13 output digits", int'(out_data), 0);
        n_got++;
      end
      if (inject && k == 0) begin
        pre_we = 1'b1; pre_addr = 8'h50; pre_data = 12'h222;
      end else begin
        pre_we = 1'b0;
      end
      if (halted) break;
    end
    check(halted, "R11 halted at end", int'(halted), 1);
  endtask

  task automatic exec_prog(input string tag, input int in_val, input bit inject);
    load_prog();
    in_data = to_bcd(in_val);
    model_run(in_val);
    run_dut(inject);
    check(n_got == n_exp, {tag, " output count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      check(got_out[i] == exp_out[i], {tag, " output value"}, got_out[i], exp_out[i]);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 100; i++) prog[i] = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    int kind;
    seed = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(halted == 1'b1, "R1 halted", int'(halted), 1);
    check(out_strobe == 1'b0, "R1 strobe", int'(out_strobe), 0);
    check(out_data == 12'h000, "R1 out_data", from_bcd(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(halted == 1'b1, "R1 halted after release", int'(halted), 1);

    // R5 R7 add wrap, store, load
    clear_prog();
    prog[0] = 550; prog[1] = 151; prog[2] = 902; prog[3] = 352;
    prog[4] = 553; prog[5] = 552; prog[6] = 902; prog[7] = 0;
    prog[50] = 789; prog[51] = 456; prog[53] = 1;
    exec_prog("R5 R7", 0, 1'b0);
    check(n_got > 0 && got_out[0] == 245, "R5 add modulo", n_got > 0 ? got_out[0] : -1, 245);

    // R6 R9 subtract below zero, conditional branches
    clear_prog();
    prog[0] = 550; prog[1] = 251; prog[2] = 902; prog[3] = 810;
    prog[4] = 902; prog[5] = 710; prog[6] = 151; prog[7] = 812;
    prog[8] = 902; prog[9] = 0; prog[10] = 902; prog[11] = 0;
    prog[12] = 252; prog[13] = 720; prog[14] = 902; prog[15] = 0;
    prog[20] = 902; prog[21] = 0;
    prog[50] = 5; prog[51] = 7; prog[52] = 5;
    exec_prog("R6 R9", 0, 1'b0);
    check(n_got == 3 && got_out[0] == 998 && got_out[2] == 0, "R6 R9 branch trace",
          n_got, 3);

    // R10 input clears negative, output strobes
    clear_prog();
    prog[0] = 550; prog[1] = 251; prog[2] = 901; prog[3] = 806;
    prog[4] = 902; prog[5] = 0; prog[6] = 902; prog[7] = 710;
    prog[8] = 902; prog[9] = 0; prog[10] = 902; prog[11] = 0;
    prog[50] = 5; prog[51] = 6;
    exec_prog("R10", 7, 1'b0);
    check(out_data == 12'h007, "R10 out_data held", from_bcd(out_data), 7);

    // R8 unconditional branch
    clear_prog();
    prog[0] = 645; prog[1] = 902; prog[2] = 0;
    prog[45] = 550; prog[46] = 902; prog[47] = 601;
    prog[50] = 321;
    exec_prog("R8", 0, 1'b0);

    // R3 timing: OUT, OUT, LOAD, OUT
    clear_prog();
    prog[0] = 902; prog[1] = 902; prog[2] = 550; prog[3] = 902; prog[4] = 0;
    prog[50] = 444;
    exec_prog("R3", 0, 1'b0);
    if (n_got == 3) begin
      check(got_k[0] == 3, "R3 first strobe cycle", got_k[0], 3);
      check(got_k[1] - got_k[0] == 4, "R3 non-memory length", got_k[1] - got_k[0], 4);
      check(got_k[2] - got_k[1] == 11, "R3 memory length", got_k[2] - got_k[1], 11);
    end else check(1'b0, "R3 strobe count", n_got, 3);

    // R11 undefined codes halt and stay halted
    clear_prog();
    prog[0] = 902; prog[1] = 412; prog[2] = 902;
    exec_prog("R11 code 412", 0, 1'b0);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (out_strobe || !halted) seen++;
      end
      check(seen == 0, "R11 frozen while halted", seen, 0);
    end
    clear_prog();
    prog[0] = 902; prog[1] = 903; prog[2] = 902;
    exec_prog("R11 code 903", 0, 1'b0);

    // R2 preload ignored while running
    clear_prog();
    prog[0] = 902; prog[1] = 550; prog[2] = 902; prog[3] = 0;
    prog[50] = 111;
    exec_prog("R2", 0, 1'b1);

    // R12 PC wraps 99 -> 00
    clear_prog();
    prog[0] = 901; prog[1] = 710; prog[2] = 699;
    prog[99] = 902; prog[10] = 902; prog[11] = 0;
    load_prog();
    in_data = to_bcd(123);
    n_got = 0;
    pulse_run();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (out_strobe && n_got < 256) begin
        got_out[n_got] = from_bcd(out_data);
        n_got++;
        in_data = 12'h000;
      end
      if (halted) break;
    end
    check(n_got == 2, "R12 output count", n_got, 2);
    if (n_got == 2) begin
      check(got_out[0] == 123, "R12 before wrap", got_out[0], 123);
      check(got_out[1] == 0, "R12 after wrap", got_out[1], 0);
    end
    acc_m = 0; neg_m = 1'b0;

    // R4 random forward-only programs, then dump ACC and data words
    for (int p = 0; p < 30; p++) begin
      clear_prog();
      for (int i = 0; i < 20; i++) begin
        kind = $urandom_range(0, 10);
        case (kind)
          0, 1: prog[i] = 100 + 50 + $urandom_range(0, 19);
          2, 3: prog[i] = 200 + 50 + $urandom_range(0, 19);
          4:    prog[i] = 300 + 50 + $urandom_range(0, 9);
          5:    prog[i] = 500 + 50 + $urandom_range(0, 19);
          6:    prog[i] = 902;
          7:    prog[i] = 901;
          8:    prog[i] = 700 + $urandom_range(i + 1, 20);
          9:    prog[i] = 800 + $urandom_range(i + 1, 20);
          default: prog[i] = ($urandom_range(0, 7) == 0) ? 400 + $urandom_range(0, 99)
                                                       : 600 + $urandom_range(i + 1, 20);
        endcase
      end
      prog[20] = 902;
      for (int j = 0; j < 10; j++) begin
        prog[21 + 2*j] = 550 + j;
        prog[22 + 2*j] = 902;
      end
      prog[41] = 0;
      for (int j = 50; j < 70; j++) prog[j] = $urandom_range(0, 999);
      if (p % 5 == 0) prog[50] = 0;
      exec_prog("R4 R5 R6 R7 R9 random", $urandom_range(0, 999), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule